// File: doc/BRIEF.md
# Display Interrupt Aggregation Controller

This block gathers the interrupt sources of a two-pipe display engine behind one interrupt line. Each pipe has a status register. Its sticky event bits record vertical-blank-start and vertical-blank pulses from the timing generator, and its enable bits choose which of those events count. The enabled events of a pipe combine into one per-pipe line. That line, the user-interrupt input and the backlight event input make up the raw status vector.

The top level tracks each raw bit with an edge detector. A rising edge is recorded in the identity register only while the matching mask bit is 0. A rise that arrives while the bit is masked is lost for good: clearing the mask later does not bring it back. The interrupt output is high whenever a set identity bit has its enable bit set.

Each pipe also counts vertical-blank pulses in a 24-bit frame counter. The counter is read as a high field and a low field, and the two fields are not captured together. Software uses a plain register bus: a one-cycle write strobe with address and data, and a read port decoded combinationally from the address. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `disp_irq_agg`

## Requirements
- R1: While reset is held and after its release, the mask register reads all ones (0xFF at address 1), the enable register (address 3) and identity register (address 2) read 0, all pipe status bits and frame counters read 0, and irq_o is 0.
- R2: A vertical-blank-start pulse on a pipe sets status bit 1 of that pipe's register, and a vertical-blank pulse sets status bit 2. This happens whatever the enables are. The enables are read and written at bit 17 (blank start) and bit 18 (blank). Pipe A is at address 4 and pipe B at address 5. A set status bit stays set until it is cleared.
- R3: Writing a 1 to a pipe status bit clears it, and writing a 0 leaves it alone. If a clearing write and a new pulse for the same bit land in the same cycle, the bit stays set.
- R4: The raw status register (address 0, read-only) shows the backlight input at bit 0, the user input at bit 1, pipe B's line at bit 4 and pipe A's line at bit 6. A pipe's line is 1 when any of its status bits is set together with its enable bit.
- R5: An identity bit is set one clock after its raw bit goes from 0 to 1, provided its mask bit (address 1, same position) is 0 at that clock.
- R6: A raw rise that happens while its mask bit is 1 never sets the identity bit, and clearing the mask while the raw bit stays high does not set it either.
- R7: Writing a 1 to an identity bit clears it. A new raw rise in the same cycle wins, and the bit stays set.
- R8: irq_o is 1 exactly when some identity bit is set and its enable-register bit is 1.
- R9: Each vertical-blank pulse increments that pipe's 24-bit frame counter. Count bits [23:8] read at bits [15:0] of the high field and count bits [7:0] read at bits [7:0] of the low field. The fields are at addresses 6/7 for pipe A and 8/9 for pipe B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbl_start_i | input | 2 | Vertical-blank-start pulses, bit 0 pipe A, bit 1 pipe B |
| vbl_i | input | 2 | Vertical-blank pulses, bit 0 pipe A, bit 1 pipe B |
| user_evt_i | input | 1 | User interrupt source level |
| blc_evt_i | input | 1 | Backlight event source level |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The bench targets the lost-edge rule. It raises a pipe line while that bit is masked and then unmasks it. A design that latched on the level would raise an identity bit and fire the interrupt at that point. It also lands a clearing write in the same cycle as a new event, both on a pipe status bit and on an identity bit. A design that let the clear win would drop that interrupt with no trace. Enabling a pipe event after its status is already set must produce a rise; a design that only watched incoming pulses would miss it. An identity bit whose enable bit is 0 must keep irq_o low. The frame count is checked past 256 pulses so that the split between the high and low fields shows.

// File: rtl/disp_irq_pkg.sv
`timescale 1ns/1ps
package disp_irq_pkg;
  localparam int ADDR_W    = 4;
  localparam int NUM_PIPES = 2;

  // identity / raw vector positions
  localparam int BIT_BLC   = 0;
  localparam int BIT_USER  = 1;
  localparam int BIT_PIPEB = 4;
  localparam int BIT_PIPEA = 6;

  // pipe status register layout: index 0 = blank start, 1 = blank
  localparam int ST_BIT [2] = '{1, 2};
  localparam int EN_BIT [2] = '{17, 18};

  localparam logic [ADDR_W-1:0] ADR_RAW   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_IDENT = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ENAB  = 4'd3;

  localparam int                PIPE_BIT [NUM_PIPES] = '{BIT_PIPEA, BIT_PIPEB};
  localparam logic [ADDR_W-1:0] STAT_ADR [NUM_PIPES] = '{4'd4, 4'd5};
  localparam logic [ADDR_W-1:0] FHI_ADR  [NUM_PIPES] = '{4'd6, 4'd8};
  localparam logic [ADDR_W-1:0] FLO_ADR  [NUM_PIPES] = '{4'd7, 4'd9};
endpackage

// File: rtl/disp_pipe_evt.sv
`timescale 1ns/1ps
module disp_pipe_evt #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vbs_i,
  input  logic               vb_i,
  input  logic               wr_i,
  input  logic [1:0]         en_wdata_i,
  input  logic [1:0]         clr_i,
  output logic [1:0]         stat_o,
  output logic [1:0]         en_o,
  output logic               line_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [1:0] evt;
  logic [1:0] clr_eff;

  assign evt     = {vb_i, vbs_i};
  assign clr_eff = wr_i ? clr_i : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o  <= '0;
      en_o    <= '0;
      frame_o <= '0;
    end else begin
      // a fresh event beats a same-cycle clear
      stat_o <= evt | (stat_o & ~clr_eff);
      if (wr_i) en_o <= en_wdata_i;
      if (vb_i) frame_o <= frame_o + 1'b1;
    end
  end

  assign line_o = |(stat_o & en_o);
endmodule

// File: rtl/disp_irq_core.sv
`timescale 1ns/1ps
module disp_irq_core #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] raw_i,
  input  logic             mask_wr_i,
  input  logic             ident_wr_i,
  input  logic             enab_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] ident_o,
  output logic [IRQ_W-1:0] enab_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q;
  logic [IRQ_W-1:0] rise;
  logic [IRQ_W-1:0] clr;

  assign rise = raw_i & ~raw_q;
  assign clr  = ident_wr_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_o  <= '1;
      ident_o <= '0;
      enab_o  <= '0;
    end else begin
      raw_q   <= raw_i;
      // the mask in force at the edge decides; later unmasking recovers nothing
      ident_o <= (ident_o & ~clr) | (rise & ~mask_o);
      if (mask_wr_i) mask_o <= wdata_i;
      if (enab_wr_i) enab_o <= wdata_i;
    end
  end

  assign irq_o = |(ident_o & enab_o);
endmodule

// File: rtl/disp_irq_agg.sv
`timescale 1ns/1ps
module disp_irq_agg
  import disp_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 8,
  parameter int FRAME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        vbl_start_i,
  input  logic [1:0]        vbl_i,
  input  logic              user_evt_i,
  input  logic              blc_evt_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int HI_W = FRAME_W - 8;

  logic [NUM_PIPES-1:0][1:0]         stat_w;
  logic [NUM_PIPES-1:0][1:0]         en_w;
  logic [NUM_PIPES-1:0]              line_w;
  logic [NUM_PIPES-1:0][FRAME_W-1:0] frame_w;
  logic [IRQ_W-1:0]                  raw_w;
  logic [IRQ_W-1:0]                  mask_w;
  logic [IRQ_W-1:0]                  ident_w;
  logic [IRQ_W-1:0]                  enab_w;
  wire                               unused_wdata = ^bus_wdata_i;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic       wr_p;
    logic [1:0] en_d;
    logic [1:0] clr_d;
    assign wr_p  = bus_wr_i && (bus_addr_i == STAT_ADR[p]);
    assign en_d  = {bus_wdata_i[EN_BIT[1]], bus_wdata_i[EN_BIT[0]]};
    assign clr_d = {bus_wdata_i[ST_BIT[1]], bus_wdata_i[ST_BIT[0]]};

    disp_pipe_evt #(.FRAME_W(FRAME_W)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .vbs_i      (vbl_start_i[p]),
      .vb_i       (vbl_i[p]),
      .wr_i       (wr_p),
      .en_wdata_i (en_d),
      .clr_i      (clr_d),
      .stat_o     (stat_w[p]),
      .en_o       (en_w[p]),
      .line_o     (line_w[p]),
      .frame_o    (frame_w[p])
    );
  end

  always_comb begin
    raw_w           = '0;
    raw_w[BIT_BLC]  = blc_evt_i;
    raw_w[BIT_USER] = user_evt_i;
    for (int p = 0; p < NUM_PIPES; p++) raw_w[PIPE_BIT[p]] = line_w[p];
  end

  disp_irq_core #(.IRQ_W(IRQ_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (raw_w),
    .mask_wr_i  (bus_wr_i && (bus_addr_i == ADR_MASK)),
    .ident_wr_i (bus_wr_i && (bus_addr_i == ADR_IDENT)),
    .enab_wr_i  (bus_wr_i && (bus_addr_i == ADR_ENAB)),
    .wdata_i    (bus_wdata_i[IRQ_W-1:0]),
    .mask_o     (mask_w),
    .ident_o    (ident_w),
    .enab_o     (enab_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADR_RAW)   bus_rdata_o[IRQ_W-1:0] = raw_w;
    if (bus_addr_i == ADR_MASK)  bus_rdata_o[IRQ_W-1:0] = mask_w;
    if (bus_addr_i == ADR_IDENT) bus_rdata_o[IRQ_W-1:0] = ident_w;
    if (bus_addr_i == ADR_ENAB)  bus_rdata_o[IRQ_W-1:0] = enab_w;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (bus_addr_i == STAT_ADR[p]) begin
        for (int b = 0; b < 2; b++) begin
          bus_rdata_o[ST_BIT[b]] = stat_w[p][b];
          bus_rdata_o[EN_BIT[b]] = en_w[p][b];
        end
      end
      if (bus_addr_i == FHI_ADR[p]) bus_rdata_o[HI_W-1:0] = frame_w[p][FRAME_W-1:8];
      if (bus_addr_i == FLO_ADR[p]) bus_rdata_o[7:0]      = frame_w[p][7:0];
    end
  end
endmodule

// File: rtl/disp_irq_chk.sv
`timescale 1ns/1ps
module disp_irq_chk
  import disp_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 8,
  parameter int FRAME_W = 24
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bus_wr_i,
  input logic [ADDR_W-1:0]                 bus_addr_i,
  input logic [DATA_W-1:0]                 bus_wdata_i,
  input logic [1:0]                        vbl_i,
  input logic [IRQ_W-1:0]                  raw_w,
  input logic [IRQ_W-1:0]                  mask_w,
  input logic [IRQ_W-1:0]                  ident_w,
  input logic [IRQ_W-1:0]                  enab_w,
  input logic [NUM_PIPES-1:0][1:0]         stat_w,
  input logic [NUM_PIPES-1:0][FRAME_W-1:0] frame_w
);
  logic [IRQ_W-1:0] id_clr;
  assign id_clr = (bus_wr_i && bus_addr_i == ADR_IDENT) ? bus_wdata_i[IRQ_W-1:0] : '0;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (mask_w == '1 && enab_w == '0 && ident_w == '0)); // R1

  AST_NEW_IDENT_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_w & ~$past(ident_w) & ~($past(raw_w) & ~$past(mask_w))) == '0); // R5

  AST_MASKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_w & ~$past(ident_w) & $past(mask_w)) == '0); // R6

  AST_IDENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ident_w & $past(ident_w & ~id_clr)) == $past(ident_w & ~id_clr))); // R7

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_p
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      vbl_i[p] |=> frame_w[p] == FRAME_W'($past(frame_w[p]) + 1'b1)); // R9
    for (genvar b = 0; b < 2; b++) begin : g_b
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[p][b] && !(bus_wr_i && bus_addr_i == STAT_ADR[p] && bus_wdata_i[ST_BIT[b]]))
        |=> stat_w[p][b]); // R2
      AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == STAT_ADR[p] && bus_wdata_i[ST_BIT[b]] && !(b == 1 && vbl_i[p]) && b == 1)
        |=> !stat_w[p][b]); // R3
    end
  end
endmodule

bind disp_irq_agg disp_irq_chk #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .FRAME_W(FRAME_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .vbl_i       (vbl_i),
  .raw_w       (raw_w),
  .mask_w      (mask_w),
  .ident_w     (ident_w),
  .enab_w      (enab_w),
  .stat_w      (stat_w),
  .frame_w     (frame_w)
);

// File: tb/disp_irq_agg_tb_top.sv
`timescale 1ns/1ps
module disp_irq_agg_tb_top;
  import disp_irq_pkg::*;
  localparam int DATA_W = 32, IRQ_W = 8, FRAME_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        vbl_start_i = '0, vbl_i = '0;
  logic              user_evt_i = 1'b0, blc_evt_i = 1'b0;
  logic              bus_wr_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [DATA_W-1:0] bus_wdata_i = '0;
  logic [DATA_W-1:0] bus_rdata_o;
  logic              irq_o;

  always #10 clk = ~clk;

  disp_irq_agg #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .FRAME_W(FRAME_W)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // ---- behavioural reference model ----
  logic [1:0]         m_en [2];
  logic [1:0]         m_st [2];
  int unsigned        m_fr [2];
  logic [7:0]         m_mask, m_id, m_ier, m_prev;

  function automatic logic [7:0] m_raw();
    logic [7:0] r = '0;
    r[0] = blc_evt_i;
    r[1] = user_evt_i;
    r[6] = |(m_st[0] & m_en[0]);
    r[4] = |(m_st[1] & m_en[1]);
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] d = '0;
    case (a)
      4'd0: d[7:0] = m_raw();
      4'd1: d[7:0] = m_mask;
      4'd2: d[7:0] = m_id;
      4'd3: d[7:0] = m_ier;
      4'd4: d = {13'd0, m_en[0], 14'd0, m_st[0], 1'b0};
      4'd5: d = {13'd0, m_en[1], 14'd0, m_st[1], 1'b0};
      4'd6: d = (m_fr[0] >> 8) & 32'hFFFF;
      4'd7: d = m_fr[0] & 32'hFF;
      4'd8: d = (m_fr[1] >> 8) & 32'hFFFF;
      4'd9: d = m_fr[1] & 32'hFF;
      default: d = '0;
    endcase
    return d;
  endfunction

  always @(posedge clk) begin
    logic [7:0] r, clr;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin m_en[p] = '0; m_st[p] = '0; m_fr[p] = 0; end
      m_mask = 8'hFF; m_id = '0; m_ier = '0; m_prev = '0;
    end else begin
      r   = m_raw();
      clr = (bus_wr_i && bus_addr_i == 4'd2) ? bus_wdata_i[7:0] : 8'h00;
      m_id = (m_id & ~clr) | (r & ~m_prev & ~m_mask);
      m_prev = r;
      if (bus_wr_i && bus_addr_i == 4'd1) m_mask = bus_wdata_i[7:0];
      if (bus_wr_i && bus_addr_i == 4'd3) m_ier  = bus_wdata_i[7:0];
      for (int p = 0; p < 2; p++) begin
        logic wr_p;
        wr_p = bus_wr_i && (bus_addr_i == 4'(4 + p));
        if (wr_p) begin
          if (bus_wdata_i[1]) m_st[p][0] = 1'b0;
          if (bus_wdata_i[2]) m_st[p][1] = 1'b0;
        end
        if (vbl_start_i[p]) m_st[p][0] = 1'b1;
        if (vbl_i[p]) begin m_st[p][1] = 1'b1; m_fr[p] = (m_fr[p] + 1) & 32'hFFFFFF; end
        if (wr_p) m_en[p] = {bus_wdata_i[18], bus_wdata_i[17]};
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq vs model", {31'd0, irq_o}, {31'd0, |(m_id & m_ier)});
      chk("R4/R5/R9 read vs model", bus_rdata_o, m_read(bus_addr_i));
    end
  end

  // one stimulus cycle; strobes drop afterwards, levels persist
  task automatic cyc(bit w, logic [3:0] a, logic [31:0] d, logic [1:0] vs, logic [1:0] v, bit u, bit b);
    @(negedge clk); #1;
    bus_wr_i = w; bus_addr_i = a; bus_wdata_i = d;
    vbl_start_i = vs; vbl_i = v; user_evt_i = u; blc_evt_i = b;
    @(negedge clk); #1;
    bus_wr_i = 1'b0; vbl_start_i = '0; vbl_i = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 2'b00, 2'b00, user_evt_i, blc_evt_i);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    bus_wr_i = 1'b0; bus_addr_i = a;
    #2 chk(tag, bus_rdata_o, exp);
  endtask

  task automatic irqchk(bit exp, string tag);
    @(negedge clk); #3 chk(tag, {31'd0, irq_o}, {31'd0, exp});
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;

    // R1 reset state
    rd(ADR_MASK, 32'hFF, "R1 mask");
    rd(ADR_ENAB, 32'h0, "R1 enable");
    rd(ADR_IDENT, 32'h0, "R1 ident");
    rd(4'd4, 32'h0, "R1 pipe A status");
    rd(4'd7, 32'h0, "R1 frame low");
    irqchk(1'b0, "R1 irq");

    // R2 sticky status with enables off; R4 raw stays low
    cyc(1'b0, ADR_RAW, 0, 2'b01, 2'b00, 1'b0, 1'b0);
    rd(4'd4, 32'h2, "R2 blank start sets bit 1");
    rd(ADR_RAW, 32'h0, "R4 disabled event not in raw");

    // R5 enabling a set status gives a rise
    wr(ADR_MASK, 32'h0);
    wr(ADR_ENAB, 32'hFF);
    wr(4'd4, 32'h1 << 17);
    rd(ADR_RAW, 32'h40, "R4 pipe A line at bit 6");
    rd(ADR_IDENT, 32'h40, "R5 pipe A identity");
    irqchk(1'b1, "R8 irq high");

    // R3 / R7 clear order: status then identity
    wr(4'd4, (32'h1 << 17) | 32'h2);
    rd(4'd4, 32'h20000, "R3 status cleared, enable kept");
    wr(ADR_IDENT, 32'h40);
    rd(ADR_IDENT, 32'h0, "R7 identity cleared");
    irqchk(1'b0, "R7 irq low after clear");

    // R8 enable gating
    wr(ADR_ENAB, 32'h0);
    cyc(1'b0, ADR_RAW, 0, 2'b01, 2'b00, 1'b0, 1'b0);
    rd(ADR_IDENT, 32'h40, "R8 identity set");
    irqchk(1'b0, "R8 gated by enable");
    wr(4'd4, (32'h1 << 17) | 32'h2);
    wr(ADR_IDENT, 32'h40);
    wr(ADR_ENAB, 32'hFF);

    // R6 masked rise is lost
    wr(ADR_MASK, 32'h10);
    wr(4'd5, 32'h1 << 18);
    cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b10, 1'b0, 1'b0);
    rd(ADR_RAW, 32'h10, "R6 pipe B raw high");
    rd(ADR_IDENT, 32'h0, "R6 masked rise not recorded");
    wr(ADR_MASK, 32'h0);
    rd(ADR_IDENT, 32'h0, "R6 unmask recovers nothing");
    irqchk(1'b0, "R6 irq stays low");

    // R5 user input; R7 set wins over clear
    cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b00, 1'b1, 1'b0);
    rd(ADR_IDENT, 32'h02, "R5 user identity");
    cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b00, 1'b0, 1'b0);
    cyc(1'b1, ADR_IDENT, 32'h02, 2'b00, 2'b00, 1'b1, 1'b0);
    rd(ADR_IDENT, 32'h02, "R7 same-cycle rise wins");

    // R4 backlight input
    cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b00, 1'b1, 1'b1);
    rd(ADR_RAW, 32'h13, "R4 raw with all level sources");
    rd(ADR_IDENT, 32'h03, "R5 backlight identity");

    // R3 set wins over status clear
    cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b01, 1'b1, 1'b1);
    cyc(1'b1, 4'd4, (32'h1 << 17) | 32'h4, 2'b00, 2'b01, 1'b1, 1'b1);
    rd(4'd4, 32'h20004, "R3 same-cycle event wins");

    // R9 frame counter split
    for (int i = 0; i < 300; i++) cyc(1'b0, ADR_RAW, 0, 2'b00, 2'b01, 1'b1, 1'b1);
    rd(4'd6, 32'h1, "R9 pipe A high field");
    rd(4'd7, 32'd46, "R9 pipe A low field");
    rd(4'd8, 32'h0, "R9 pipe B high field");
    rd(4'd9, 32'h1, "R9 pipe B low field");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule